// File: doc/BRIEF.md
# Shift-Register LIFO Stack

This block is a small last-in-first-out store made of a column of parallel-load byte registers. No read or write pointer exists. The top of the stack is always the first register, and the stored data moves through the column. A push loads the incoming byte into the top register and moves every older entry one place deeper. A pop takes the byte from the top register and moves every deeper entry one place up. The register left empty at the bottom is cleared.

The top register drives the read port directly, through combinational logic. A consumer therefore sees the byte that a pop will remove before it issues the pop. An occupancy count from zero to the depth drives the full and empty flags. A push into a full stack, or a pop from an empty stack, changes nothing and produces a one-cycle error pulse. When push and pop are requested in the same cycle, the top entry is replaced in place.

Top module: `shift_lifo`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the stack empties: `count_o` becomes 0, `empty_o` becomes 1, `full_o` becomes 0, `data_o` becomes 0, and both error pulses go low.
- R2: A push alone into a stack that is not full works as follows. After the edge, `data_o` equals the pushed byte and `count_o` is one higher. Earlier entries move one place deeper and keep their order.
- R3: A push alone into a full stack (count 5) leaves the contents and the count unchanged. `overflow_o` is high for exactly the one cycle after that edge.
- R4: Before a pop, `data_o` shows the byte being removed. A pop alone from a stack that is not empty lowers `count_o` by one. After it, `data_o` shows the next-older entry, so bytes come out in the reverse of the order in which they were pushed.
- R5: A pop alone from an empty stack leaves the count at 0 and `data_o` at 0. `underflow_o` is high for exactly the one cycle after that edge.
- R6: Push and pop together on a stack that is not empty (including a full stack) replace the top entry with `data_i`. Deeper entries and the count are unchanged, and no error pulse is raised.
- R7: Push and pop together on an empty stack act as a push. The count becomes 1, `data_o` shows `data_i`, and no underflow pulse is raised.
- R8: `empty_o` is high exactly when the count is 0. `full_o` is high exactly when the count equals the depth of 5. The count never exceeds 5.
- R9: A register left vacant by a pop is cleared to zero. As a result, `data_o` reads 0 whenever the stack is empty, and stale bytes never reappear after the stack has been drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| data_i | input | 8 | Byte to push |
| data_o | output | 8 | Current top of stack (combinational from the top register) |
| full_o | output | 1 | Stack holds 5 entries |
| empty_o | output | 1 | Stack holds no entries |
| count_o | output | 3 | Number of stored entries, 0 to 5 |
| overflow_o | output | 1 | One-cycle pulse after a rejected push |
| underflow_o | output | 1 | One-cycle pulse after a rejected pop |

## Verification
The hardest case to reach is the bottom-clear rule. A stale byte in a vacated register only shows up later, after the stack has been filled completely, drained and then partly refilled and popped again. The stimulus table therefore drives the stack to full, pushes once more into the full stack, and replaces the top while full. It then drains the stack past empty and refills it, checking every `data_o` value on the way. Directed sequences then push and pop together on an empty stack, and repeat the fill-and-drain cycle to confirm that only zeros rise to the top.

// File: rtl/lifo_pkg.sv
// Package: shared types for the shift-register LIFO.
// Assumes: one operation per cycle, decided from push/pop and the flags.
package lifo_pkg;

    // Resolved per-cycle action of the whole register column
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,   // nothing moves
        OP_PUSH  = 3'd1,   // load top, shift all entries deeper
        OP_POP   = 3'd2,   // shift all entries up, clear bottom
        OP_SWAP  = 3'd3,   // replace top only
        OP_OVF   = 3'd4,   // rejected push, nothing moves
        OP_UNF   = 3'd5    // rejected pop, nothing moves
    } lifo_op_t;

endpackage

// File: rtl/lifo_op_decode.sv
// Module: lifo_op_decode
// Turns the raw push/pop requests and the current fill state into one
// resolved operation for the register column and the counter.
// Assumes: is_empty and is_full are never both high.
module lifo_op_decode
    import lifo_pkg::*;
(
    input  logic     push,
    input  logic     pop,
    input  logic     is_empty,
    input  logic     is_full,
    output lifo_op_t op
);

    // Priority: simultaneous request first, then single requests
    always_comb begin
        op = OP_HOLD;
        if (push && pop) begin
            op = is_empty ? OP_PUSH : OP_SWAP;
        end else if (push) begin
            op = is_full ? OP_OVF : OP_PUSH;
        end else if (pop) begin
            op = is_empty ? OP_UNF : OP_POP;
        end
    end

endmodule

// File: rtl/lifo_stage.sv
// Module: lifo_stage
// One byte register of the column. On a push it loads the value handed
// down from above (the input byte for the top stage); on a pop it loads
// the value from below (zero for the bottom stage); on a swap only the
// top stage loads the input byte.
// Assumes: the caller wires push_src / pop_src to the correct neighbours.
module lifo_stage
    import lifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter bit IS_TOP = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lifo_op_t          op,
    input  logic [DATA_W-1:0] push_src,
    input  logic [DATA_W-1:0] pop_src,
    output logic [DATA_W-1:0] q
);

    logic [DATA_W-1:0] q_next;

    // Select the next contents of this stage from the resolved operation
    always_comb begin
        q_next = q;
        case (op)
            OP_PUSH: q_next = push_src;
            OP_POP:  q_next = pop_src;
            OP_SWAP: if (IS_TOP) q_next = push_src;
            default: q_next = q;
        endcase
    end

    // Stage register with synchronous active-low clear
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end

endmodule

// File: rtl/lifo_occupancy.sv
// Module: lifo_occupancy
// Tracks how many entries the column holds, derives the full and empty
// flags, and registers the one-cycle overflow and underflow pulses.
// Assumes: op was resolved against the flags this module produces.
module lifo_occupancy
    import lifo_pkg::*;
#(
    parameter int DEPTH = 5,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lifo_op_t         op,
    output logic [CNT_W-1:0] count,
    output logic             is_empty,
    output logic             is_full,
    output logic             ovf_pulse,
    output logic             unf_pulse
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    // Entry counter: up on push, down on pop, held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case (op)
                OP_PUSH: count <= count + 1'b1;
                OP_POP:  count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Error pulses, high for the cycle after a rejected request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_pulse <= 1'b0;
            unf_pulse <= 1'b0;
        end else begin
            ovf_pulse <= (op == OP_OVF);
            unf_pulse <= (op == OP_UNF);
        end
    end

    // Fill flags straight from the count
    always_comb begin
        is_empty = (count == '0);
        is_full  = (count == CNT_MAX);
    end

endmodule

// File: rtl/shift_lifo.sv
// Module: shift_lifo (top)
// Last-in-first-out byte store built from a chain of DEPTH registers in
// which data moves instead of a pointer. Stage 0 is always the top and
// drives data_o combinationally.
// Assumes: requests are synchronous to clk; the reset is synchronous.
module shift_lifo
    import lifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 5,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o,
    output logic              empty_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              overflow_o,
    output logic              underflow_o
);

    lifo_op_t          op;
    logic              is_empty;
    logic              is_full;
    logic [DATA_W-1:0] stage_q [DEPTH];

    lifo_op_decode u_decode (
        .push     (push_i),
        .pop      (pop_i),
        .is_empty (is_empty),
        .is_full  (is_full),
        .op       (op)
    );

    lifo_occupancy #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_occ (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .count     (count_o),
        .is_empty  (is_empty),
        .is_full   (is_full),
        .ovf_pulse (overflow_o),
        .unf_pulse (underflow_o)
    );

    // Register column: each stage sees its upper and lower neighbour
    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        logic [DATA_W-1:0] from_above;
        logic [DATA_W-1:0] from_below;

        if (k == 0) begin : g_top_src
            assign from_above = data_i;
        end else begin : g_mid_src
            assign from_above = stage_q[k-1];
        end

        if (k == DEPTH - 1) begin : g_bot_src
            assign from_below = '0;
        end else begin : g_up_src
            assign from_below = stage_q[k+1];
        end

        lifo_stage #(
            .DATA_W (DATA_W),
            .IS_TOP (k == 0)
        ) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .op       (op),
            .push_src (from_above),
            .pop_src  (from_below),
            .q        (stage_q[k])
        );
    end

    // Outputs: top register and flags
    always_comb begin
        data_o  = stage_q[0];
        full_o  = is_full;
        empty_o = is_empty;
    end

endmodule

// File: rtl/lifo_checker.sv
// Module: lifo_checker
// Port-level temporal properties of shift_lifo, attached by bind.
// Assumes: same parameters as the bound instance.
module lifo_checker #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 5,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_i,
    input logic              pop_i,
    input logic [DATA_W-1:0] data_i,
    input logic [DATA_W-1:0] data_o,
    input logic              full_o,
    input logic              empty_o,
    input logic [CNT_W-1:0]  count_o,
    input logic              overflow_o,
    input logic              underflow_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    p_push_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !full_o) |=>
            (data_o == $past(data_i)) && (count_o == CNT_W'($past(count_o) + 1'b1)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && full_o) |=>
            overflow_o && $stable(count_o) && $stable(data_o));

    p_ovf_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> $past(push_i && !pop_i && full_o));

    p_pop_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !empty_o) |=>
            (count_o == CNT_W'($past(count_o) - 1'b1)) && !underflow_o);

    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty_o) |=> underflow_o && empty_o);

    p_unf_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |-> $past(pop_i && !push_i && empty_o));

    p_swap_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !empty_o) |=>
            (data_o == $past(data_i)) && $stable(count_o) && !overflow_o);

    p_both_on_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && empty_o) |=>
            (count_o == CNT_W'(1)) && !underflow_o);

    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o <= CNT_MAX) && !(full_o && empty_o));

    p_empty_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> (data_o == '0));

endmodule

bind shift_lifo lifo_checker #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W)
) u_lifo_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .data_i      (data_i),
    .data_o      (data_o),
    .full_o      (full_o),
    .empty_o     (empty_o),
    .count_o     (count_o),
    .overflow_o  (overflow_o),
    .underflow_o (underflow_o)
);

// File: tb/tb_shift_lifo.sv
// Bench for shift_lifo: a vector table walked by one loop, then directed
// tests for reset, push/pop together on empty, and bottom clearing.
module tb_shift_lifo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_i = 1'b0;
    logic       pop_i = 1'b0;
    logic [7:0] data_i = 8'h00;
    logic [7:0] data_o;
    logic       full_o;
    logic       empty_o;
    logic [2:0] count_o;
    logic       overflow_o;
    logic       underflow_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    shift_lifo dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .pop_i       (pop_i),
        .data_i      (data_i),
        .data_o      (data_o),
        .full_o      (full_o),
        .empty_o     (empty_o),
        .count_o     (count_o),
        .overflow_o  (overflow_o),
        .underflow_o (underflow_o)
    );

    // Vector fields: push, pop, din[8], exp dout[8], exp count[3], exp ovf, exp unf
    localparam int NV = 21;
    localparam logic [22:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'h11, 8'h11, 3'd1, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'h22, 8'h22, 3'd2, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'h33, 8'h33, 3'd3, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'h44, 8'h44, 3'd4, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'h55, 8'h55, 3'd5, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'h66, 8'h55, 3'd5, 1'b1, 1'b0},
        {1'b0, 1'b0, 8'h00, 8'h55, 3'd5, 1'b0, 1'b0},
        {1'b1, 1'b1, 8'h77, 8'h77, 3'd5, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h00, 8'h44, 3'd4, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h00, 8'h33, 3'd3, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h00, 8'h22, 3'd2, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h00, 8'h11, 3'd1, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h00, 8'h00, 3'd0, 1'b0, 1'b1},
        {1'b0, 1'b0, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0},
        {1'b1, 1'b1, 8'h88, 8'h88, 3'd1, 1'b0, 1'b0},
        {1'b1, 1'b1, 8'h99, 8'h99, 3'd1, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'hAA, 8'hAA, 3'd2, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h00, 8'h99, 3'd1, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0},
        {1'b0, 1'b0, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0}
    };

    task automatic check(input string req, input string what,
                         input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, actual, expected);
        end
    endtask

    // Drive one request at a falling edge, let one rising edge pass, return at next falling edge
    task automatic step(input logic p, input logic q, input logic [7:0] d);
        push_i = p;
        pop_i  = q;
        data_i = d;
        @(posedge clk);
        @(negedge clk);
        push_i = 1'b0;
        pop_i  = 1'b0;
    endtask

    task automatic check_flags(input int exp_cnt);
        check("R8", "count", int'(count_o), exp_cnt);
        check("R8", "empty", int'(empty_o), int'(exp_cnt == 0));
        check("R8", "full", int'(full_o), int'(exp_cnt == 5));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : main
        @(negedge clk);
        do_reset();

        // R1: state after reset
        check("R1", "dout", int'(data_o), 0);
        check("R1", "ovf", int'(overflow_o), 0);
        check("R1", "unf", int'(underflow_o), 0);
        check_flags(0);

        // Table walk: R2 push, R3 full push, R4 pop order, R5 empty pop, R6 swap
        for (int i = 0; i < NV; i++) begin
            logic [22:0] v;
            string tag;
            v = VEC[i];
            if (v[22] && v[21])  tag = "R6";
            else if (v[22])      tag = "R2";
            else if (v[21])      tag = "R4";
            else                 tag = "R8";
            step(v[22], v[21], v[20:13]);
            check(tag, "dout", int'(data_o), int'(v[12:5]));
            check("R3", "ovf", int'(overflow_o), int'(v[1]));
            check("R5", "unf", int'(underflow_o), int'(v[0]));
            check_flags(int'(v[4:2]));
        end

        // R1: reset clears a partly filled stack
        step(1'b1, 1'b0, 8'hE1);
        step(1'b1, 1'b0, 8'hE2);
        do_reset();
        check("R1", "dout after reset", int'(data_o), 0);
        check("R1", "count after reset", int'(count_o), 0);
        step(1'b0, 1'b1, 8'h00);
        check("R1", "unf after reset pop", int'(underflow_o), 1);

        // R7: push and pop together on empty behave as a push
        do_reset();
        step(1'b1, 1'b1, 8'h5A);
        check("R7", "dout", int'(data_o), 'h5A);
        check("R7", "count", int'(count_o), 1);
        check("R7", "unf", int'(underflow_o), 0);
        step(1'b0, 1'b1, 8'h00);
        check("R9", "dout drained", int'(data_o), 0);

        // R9: fill, drain, refill one, pop twice - only zeros rise
        for (int k = 1; k <= 5; k++) step(1'b1, 1'b0, 8'(8'hC0 + k));
        check("R3", "full reached", int'(full_o), 1);
        for (int k = 5; k >= 1; k--) begin
            check("R4", "pop order", int'(data_o), 'hC0 + k);
            step(1'b0, 1'b1, 8'h00);
        end
        check("R9", "dout empty", int'(data_o), 0);
        step(1'b1, 1'b0, 8'h3C);
        step(1'b1, 1'b0, 8'h4D);
        step(1'b0, 1'b1, 8'h00);
        check("R4", "after pop", int'(data_o), 'h3C);
        step(1'b0, 1'b1, 8'h00);
        check("R9", "no stale byte", int'(data_o), 0);
        check_flags(0);

        finish_run();
    end

endmodule